// File: doc/BRIEF.md
# Fail-Only Bit Position Logger

This block watches a serial receive stream whose expected value is zero at every bit. It keeps no copy of the stream. It stores only the positions of the bits that arrive as one, and it counts those positions from the cycle where the frame enable line rises. A bit that arrives as zero passes and leaves no trace. The amount of stored data therefore grows with the number of set bits. Small positive two's-complement samples have few set bits, so they cost almost nothing to log.

A capture starts with a one-cycle `start` pulse. The logger then waits for a low-to-high transition of `en`. It records one position per cycle while `en` stays high, and it stops when `en` drops. The position log can be read back by index. After a capture, a one-cycle `rebuild` pulse starts a single walk over every bit position of the capture window. This walk merges the sorted log into a store of 16-bit words that can be read by sample index. Bits that fall in the padding part of a frame are skipped.

Each frame is `FRAME_BITS` long. Its first `WORDS_PER_FRAME * WORD_BITS` bits carry sample words, and the remaining bits are padding. The defaults are 96-bit frames, each carrying an I word and a Q word of 16 bits followed by 64 padding bits, and 18-bit positions.

Top module: `fail_pos_logger`

## Requirements
- R1: After reset, `fail_count` is 0, `full` is 0, `busy` is 0, and every `rd_word` reads 0.
- R2: After `start`, position 0 is the first cycle in which `en` is high after a cycle in which it was low. Bits that arrive before that edge are not logged. If `en` is already high when `start` is given, nothing is logged until `en` has gone low and then high again.
- R3: In each counted cycle with `din`=1, the current position is written at log index `fail_count` and `fail_count` rises by 1. A cycle with `din`=0 stores nothing. Logged positions are strictly increasing and can be read on `pos_rd_data` at index `pos_rd_addr`.
- R4: The capture ends in the first cycle in which `en` is low. After that, `din` and `en` have no effect on `fail_count` or on the log until the next `start`.
- R5: When a one arrives while the log already holds `DEPTH` entries, `full` goes to 1, the position is not stored, and `fail_count` stays at `DEPTH`. `full` stays set until the next `start`.
- R6: A `start` pulse clears `fail_count` and `full`, and restarts the search for a rising `en` edge. This holds even while a capture is running.
- R7: After `rebuild`, word `k` (read with `rd_idx`=k) belongs to frame `k / WORDS_PER_FRAME` and to slot `k % WORDS_PER_FRAME` within that frame. Slot `s` covers frame offsets `s*WORD_BITS` up to `s*WORD_BITS+WORD_BITS-1`, and the first offset of the slot is bit 15 (the MSB). Exactly the logged bits are set; every other bit reads 0.
- R8: Logged positions at frame offsets of `WORDS_PER_FRAME*WORD_BITS` or more are padding. They never change any rebuilt word.
- R9: `busy` rises in the cycle after `rebuild`. It stays high for exactly `FRAME_BITS*NUM_FRAMES` cycles, one cycle per bit position, and then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Arms a new capture and clears the log |
| en | input | 1 | Frame enable; its rising edge marks position 0 |
| din | input | 1 | Serial receive bit; a one is logged as a fail |
| rebuild | input | 1 | Starts the word reconstruction walk |
| pos_rd_addr | input | 6 | Log index to read |
| rd_idx | input | 4 | Sample index of the rebuilt word to read |
| pos_rd_data | output | 18 | Logged position at `pos_rd_addr` |
| fail_count | output | 7 | Number of positions stored in the log |
| full | output | 1 | A one arrived after the log was full |
| busy | output | 1 | The reconstruction walk is running |
| rd_word | output | 16 | Rebuilt word at `rd_idx` |

## Verification
The assertions assume that `rebuild` is not pulsed while a capture is running. This matters because the walk reads `fail_count` as a fixed bound. They also assume that `rebuild` is not pulsed again while `busy` is high.

The stimulus keeps within these limits. It drops `en` before it issues `rebuild`, and it waits for `busy` to fall before it starts another capture.

Under these conditions, the assertions check three things: the log stays strictly increasing, the full flag stays set until the next `start`, and the walk leaves the word store untouched while it passes over padding offsets.

// File: rtl/fpl_pkg.sv
package fpl_pkg;
    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_RUN   = 2'd2,
        CAP_DONE  = 2'd3
    } cap_phase_e;
endpackage

// File: rtl/fpl_capture.sv
module fpl_capture
    import fpl_pkg::*;
#(
    parameter int POS_W = 18,
    parameter int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             en,
    input  logic             din,
    input  logic [AW-1:0]    rd_addr_a,
    input  logic [AW-1:0]    rd_addr_b,
    output logic [POS_W-1:0] rd_data_a,
    output logic [POS_W-1:0] rd_data_b,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

    typedef struct packed {
        cap_phase_e                   phase;
        logic                         en_prev;
        logic [POS_W-1:0]             pos;
        logic [CNT_W-1:0]             cnt;
        logic                         full;
        logic [DEPTH-1:0][POS_W-1:0]  mem;
    } cap_state_t;

    cap_state_t q, d;
    logic             take_bit;
    logic [POS_W-1:0] take_pos;

    always_comb begin
        d        = q;
        d.en_prev = en;
        take_bit = 1'b0;
        take_pos = q.pos;
        if (start) begin
            d.phase = CAP_ARMED;
            d.cnt   = '0;
            d.full  = 1'b0;
            d.pos   = '0;
        end else begin
            case (q.phase)
                CAP_ARMED: begin
                    if (en && !q.en_prev) begin
                        d.phase  = CAP_RUN;
                        take_bit = 1'b1;
                        take_pos = '0;
                        d.pos    = POS_W'(1);
                    end
                end
                CAP_RUN: begin
                    if (!en) begin
                        d.phase = CAP_DONE;
                    end else begin
                        take_bit = 1'b1;
                        if (q.pos != POS_MAX) d.pos = q.pos + 1'b1;
                    end
                end
                default: ;
            endcase
        end
        if (take_bit && din && take_pos != POS_MAX) begin
            if (q.cnt == CNT_W'(DEPTH)) begin
                d.full = 1'b1;
            end else begin
                d.mem[q.cnt[AW-1:0]] = take_pos;
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase   <= CAP_IDLE;
            q.en_prev <= 1'b0;
            q.pos     <= '0;
            q.cnt     <= '0;
            q.full    <= 1'b0;
            q.mem     <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_data_a = q.mem[rd_addr_a];
    assign rd_data_b = q.mem[rd_addr_b];
    assign count     = q.cnt;
    assign full      = q.full;

    a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt >= CNT_W'(2)) |->
            (q.mem[AW'(q.cnt - CNT_W'(1))] > q.mem[AW'(q.cnt - CNT_W'(2))]));

    a_r4_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == CAP_DONE && !start) |=> ($stable(q.cnt) && $stable(q.mem)));

    a_r5_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q.full && !start) |=> q.full);

    a_r5_full_at_depth: assert property (@(posedge clk) disable iff (!rst_n)
        q.full |-> (q.cnt == CNT_W'(DEPTH)));

    a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (q.cnt == '0 && !q.full));
endmodule

// File: rtl/fpl_merge.sv
module fpl_merge #(
    parameter int POS_W           = 18,
    parameter int DEPTH           = 64,
    parameter int FRAME_BITS      = 96,
    parameter int WORD_BITS       = 16,
    parameter int WORDS_PER_FRAME = 2,
    parameter int NUM_FRAMES      = 8,
    localparam int AW        = $clog2(DEPTH),
    localparam int CNT_W     = $clog2(DEPTH + 1),
    localparam int NUM_WORDS = NUM_FRAMES * WORDS_PER_FRAME,
    localparam int IDX_W     = $clog2(NUM_WORDS),
    localparam int WIDX_W    = $clog2(NUM_WORDS + 1),
    localparam int DATA_BITS = WORD_BITS * WORDS_PER_FRAME,
    localparam int TOTAL     = FRAME_BITS * NUM_FRAMES,
    localparam int OFF_W     = $clog2(FRAME_BITS),
    localparam int BIT_W     = $clog2(WORD_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go,
    input  logic [CNT_W-1:0]     fail_count,
    input  logic [POS_W-1:0]     log_data,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [AW-1:0]        log_addr,
    output logic                 busy,
    output logic [WORD_BITS-1:0] rd_word
);
    typedef struct packed {
        logic                                busy;
        logic [CNT_W-1:0]                    ptr;
        logic [POS_W-1:0]                    pos;
        logic [OFF_W-1:0]                    off;
        logic [BIT_W-1:0]                    bitn;
        logic [WIDX_W-1:0]                   widx;
        logic [NUM_WORDS-1:0][WORD_BITS-1:0] words;
    } mrg_state_t;

    mrg_state_t q, d;
    logic hit, in_data;

    always_comb begin
        d       = q;
        in_data = (q.off < OFF_W'(DATA_BITS));
        hit     = (q.ptr < fail_count) && (log_data == q.pos);
        if (go) begin
            d.busy  = 1'b1;
            d.ptr   = '0;
            d.pos   = '0;
            d.off   = '0;
            d.bitn  = BIT_W'(WORD_BITS - 1);
            d.widx  = '0;
            d.words = '0;
        end else if (q.busy) begin
            if (hit) begin
                d.ptr = q.ptr + 1'b1;
                if (in_data && q.widx < WIDX_W'(NUM_WORDS))
                    d.words[q.widx[IDX_W-1:0]][q.bitn] = 1'b1;
            end
            if (in_data) begin
                if (q.bitn == '0) begin
                    d.bitn = BIT_W'(WORD_BITS - 1);
                    d.widx = q.widx + 1'b1;
                end else begin
                    d.bitn = q.bitn - 1'b1;
                end
            end
            d.off = (q.off == OFF_W'(FRAME_BITS - 1)) ? '0 : q.off + 1'b1;
            d.pos = q.pos + 1'b1;
            if (q.pos == POS_W'(TOTAL - 1)) d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.busy  <= 1'b0;
            q.ptr   <= '0;
            q.pos   <= '0;
            q.off   <= '0;
            q.bitn  <= '0;
            q.widx  <= '0;
            q.words <= '0;
        end else begin
            q <= d;
        end
    end

    assign log_addr = q.ptr[AW-1:0];
    assign busy     = q.busy;
    assign rd_word  = q.words[rd_idx];

    a_r8_pad_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !go && q.off >= OFF_W'(DATA_BITS)) |=> $stable(q.words));

    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !go && q.pos != POS_W'(TOTAL - 1)) |=> q.busy);

    a_r9_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !go && q.pos == POS_W'(TOTAL - 1)) |=> !q.busy);

    a_r7_idle_words: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.busy && !go) |=> $stable(q.words));
endmodule

// File: rtl/fail_pos_logger.sv
module fail_pos_logger #(
    parameter int POS_W           = 18,
    parameter int DEPTH           = 64,
    parameter int FRAME_BITS      = 96,
    parameter int WORD_BITS       = 16,
    parameter int WORDS_PER_FRAME = 2,
    parameter int NUM_FRAMES      = 8,
    localparam int AW        = $clog2(DEPTH),
    localparam int CNT_W     = $clog2(DEPTH + 1),
    localparam int IDX_W     = $clog2(NUM_FRAMES * WORDS_PER_FRAME)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 en,
    input  logic                 din,
    input  logic                 rebuild,
    input  logic [AW-1:0]        pos_rd_addr,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [POS_W-1:0]     pos_rd_data,
    output logic [CNT_W-1:0]     fail_count,
    output logic                 full,
    output logic                 busy,
    output logic [WORD_BITS-1:0] rd_word
);
    logic [AW-1:0]    merge_addr;
    logic [POS_W-1:0] merge_data;

    fpl_capture #(.POS_W(POS_W), .DEPTH(DEPTH)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .en        (en),
        .din       (din),
        .rd_addr_a (pos_rd_addr),
        .rd_addr_b (merge_addr),
        .rd_data_a (pos_rd_data),
        .rd_data_b (merge_data),
        .count     (fail_count),
        .full      (full)
    );

    fpl_merge #(
        .POS_W(POS_W), .DEPTH(DEPTH), .FRAME_BITS(FRAME_BITS),
        .WORD_BITS(WORD_BITS), .WORDS_PER_FRAME(WORDS_PER_FRAME),
        .NUM_FRAMES(NUM_FRAMES)
    ) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (rebuild),
        .fail_count (fail_count),
        .log_data   (merge_data),
        .rd_idx     (rd_idx),
        .log_addr   (merge_addr),
        .busy       (busy),
        .rd_word    (rd_word)
    );
endmodule

// File: tb/tb_fail_pos_logger.sv
module tb_fail_pos_logger;
    localparam int NF = 8;
    localparam int FB = 96;
    localparam int DEPTH = 64;
    // each entry: {I word, Q word} of one frame
    localparam logic [31:0] SAMPLES [NF] = '{
        32'h0000_0000, 32'h0001_0002, 32'h8000_0003, 32'hFFFF_0000,
        32'h0010_7F00, 32'h0000_8001, 32'hFFFE_0004, 32'h0000_0001
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 0, en = 0, din = 0, rebuild = 0;
    logic [5:0]  pos_rd_addr = '0;
    logic [3:0]  rd_idx = '0;
    logic [17:0] pos_rd_data;
    logic [6:0]  fail_count;
    logic        full, busy;
    logic [15:0] rd_word;

    int checks = 0, failures = 0, cycles = 0;
    int exp_pos [DEPTH];
    int exp_n;

    fail_pos_logger dut (
        .clk(clk), .rst_n(rst_n), .start(start), .en(en), .din(din),
        .rebuild(rebuild), .pos_rd_addr(pos_rd_addr), .rd_idx(rd_idx),
        .pos_rd_data(pos_rd_data), .fail_count(fail_count), .full(full),
        .busy(busy), .rd_word(rd_word)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired act=%0d exp=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic e, input logic b);
        @(negedge clk);
        en = e; din = b;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        int hi_cycles;
        int ones;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 fail_count", int'(fail_count), 0);
        chk("R1 full", int'(full), 0);
        chk("R1 busy", int'(busy), 0);
        for (int k = 0; k < 16; k++) begin
            rd_idx = 4'(k); #1;
            chk("R1 word", int'(rd_word), 0);
        end

        // Table walk: 8 frames, data plus one padding one per frame
        pulse_start();
        exp_n = 0;
        for (int f = 0; f < NF; f++) begin
            for (int o = 0; o < FB; o++) begin
                logic b;
                b = (o < 32) ? SAMPLES[f][31 - o] : (o == 32 + f * 7);
                drive(1'b1, b);
                if (b) begin
                    exp_pos[exp_n] = f * FB + o;
                    exp_n = exp_n + 1;
                end
            end
        end
        drive(1'b0, 1'b0);
        @(negedge clk);
        chk("R3 fail_count", int'(fail_count), exp_n);
        for (int i = 0; i < exp_n; i++) begin
            pos_rd_addr = 6'(i); #1;
            chk("R3 logged position", int'(pos_rd_data), exp_pos[i]);
        end
        // R4: activity after the frame end is ignored
        drive(1'b1, 1'b1);
        drive(1'b0, 1'b1);
        drive(1'b1, 1'b1);
        drive(1'b0, 1'b0);
        @(negedge clk);
        chk("R4 fail_count after end", int'(fail_count), exp_n);

        // R9: rebuild timing
        @(negedge clk);
        rebuild = 1'b1;
        @(negedge clk);
        rebuild = 1'b0;
        chk("R9 busy rises", int'(busy), 1);
        hi_cycles = 1;
        while (busy) begin
            @(negedge clk);
            if (busy) hi_cycles = hi_cycles + 1;
        end
        chk("R9 busy length", hi_cycles, NF * FB);
        // R7 and R8: words equal the data, padding ones dropped
        for (int k = 0; k < 16; k++) begin
            rd_idx = 4'(k); #1;
            if (k % 2 == 0)
                chk("R7 R8 I word", int'(rd_word), int'(SAMPLES[k / 2][31:16]));
            else
                chk("R7 R8 Q word", int'(rd_word), int'(SAMPLES[k / 2][15:0]));
        end

        // R2: en already high at start is not an edge
        drive(1'b1, 1'b0);
        pulse_start();
        drive(1'b1, 1'b1);
        drive(1'b1, 1'b1);
        @(negedge clk);
        chk("R2 no edge no log", int'(fail_count), 0);
        drive(1'b0, 1'b1);
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b1);
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b1);
        drive(1'b0, 1'b0);
        @(negedge clk);
        chk("R2 count from edge", int'(fail_count), 2);
        pos_rd_addr = 6'd0; #1;
        chk("R2 first position", int'(pos_rd_data), 1);
        pos_rd_addr = 6'd1; #1;
        chk("R2 second position", int'(pos_rd_data), 3);

        // R5 overflow, then R6 restart mid-capture clears it
        pulse_start();
        ones = 0;
        for (int i = 0; i < 70; i++) begin
            drive(1'b1, 1'b1);
            ones = ones + 1;
        end
        @(negedge clk);
        chk("R5 count capped", int'(fail_count), DEPTH);
        chk("R5 full set", int'(full), 1);
        pos_rd_addr = 6'd63; #1;
        chk("R5 last stored position", int'(pos_rd_data), 63);
        // R6: start while en still high
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R6 count cleared", int'(fail_count), 0);
        chk("R6 full cleared", int'(full), 0);
        drive(1'b1, 1'b1);
        @(negedge clk);
        chk("R6 rearm waits for edge", int'(fail_count), 0);
        drive(1'b0, 1'b0);
        drive(1'b1, 1'b1);
        drive(1'b0, 1'b0);
        @(negedge clk);
        chk("R6 new capture", int'(fail_count), 1);
        pos_rd_addr = 6'd0; #1;
        chk("R6 new position zero", int'(pos_rd_data), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule